// File: doc/BRIEF.md
# EPON 64B/66B Transmit Encoder

This block sits in the transmit path of a 25 Gb/s EPON physical coding sublayer, between the media-independent interface and the scrambler. Each accepted input is one 72-bit extended-quad vector: eight control flags plus eight octets, gathered from two consecutive 25GMII transfers. The encoder sorts the vector into a class: idle, inter-envelope idle, parity placeholder, start, data, terminate or other. It checks that class against the class of the block it sent last, and emits one 66-bit coded block with a 2-bit sync header.

A vector whose class may not follow the previous block is replaced by an error block. Out of reset the encoder first offers a local-fault block. From then on only an inter-envelope idle is accepted as the next legal class, so the stream always opens on envelope spacing. Both sides use a valid/ready handshake. The output register is the only storage, so an accepted vector appears at the output one cycle later.

Lane convention: `in_ctrl[i]` flags octet `i`, which is carried on `in_data[8*i+7:8*i]`. Lane 0 is the first octet in time.

Top module: `epon_blk_encoder`

## Requirements
- R1: While reset is asserted and after its release, the output holds a local-fault block with `out_valid`=1: header 2'b10, type 0x1E, 56-bit payload equal to `FAULT_CODES` (default 56'h7F). After the first accepted vector the local-fault block is never produced again.
- R2: The value of `out_block[1:0]` is 2'b01 for an all-data block and 2'b10 for a control block. A control block carries its type in `out_block[9:2]`. An all-data input (`in_ctrl`=0x00) gives a block with octet `i` at `out_block[8*i+9:8*i+2]`.
- R3: Every control block type produced is one of 0x1E, 0x78, 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF. The types 0x2D, 0x33, 0x4B, 0x55 and 0x66 never appear.
- R4: A vector with all flags set and every octet 0x07 (idle), 0x08 (inter-envelope idle) or 0x09 (parity placeholder) encodes as type 0x1E. Its eight 7-bit codes are 0x00, 0x08 or 0x09 respectively, and lane `i`'s code sits at `out_block[7*i+16:7*i+10]`.
- R5: A start vector has `in_ctrl`=0x01 and octet 0 = 0xFB. It encodes as type 0x78, with input octet `j` (j=1..7) at `out_block[8*j+9:8*j+2]`.
- R6: A terminate vector at lane k has flags set exactly in lanes k..7, octet k = 0xFD, and every later control octet in {0x07, 0x08, 0x09, 0xFE}. It encodes with type 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF for k = 0..7. Octets 0..k-1 go to payload bytes 0..k-1 (bits `8*j+17:8*j+10`), and all other payload bits are 0.
- R7: The class may follow the previous block's class as shown here. After local fault, only inter-envelope idle. After inter-envelope idle, inter-envelope idle, start or parity placeholder. After idle or terminate, anything but terminate. After start, data, parity placeholder or error, any class.
- R8: A disallowed vector is replaced by an error block: type 0x1E with all eight codes 0x1E. The next vector is then judged as if the previous block had been start or data, so any class except "other" is allowed.
- R9: A vector matching none of the classes of R2, R4, R5 and R6 is class "other" and always yields an error block. Examples are a mix of control characters, a terminate followed by an illegal control character, or lane 0 flagged with an octet other than 0xFB.
- R10: `in_ready` equals `!out_valid || out_ready`. A transfer happens when `in_valid` and `in_ready` are both high, and each transfer produces exactly one block. The block is registered with a one-cycle latency. A block is held stable while `out_valid` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Encoder can take a vector this cycle |
| in_ctrl | input | 8 | Per-lane control flags, bit i for octet i |
| in_data | input | 64 | Eight octets, octet i at bits 8i+7:8i |
| out_valid | output | 1 | Coded block present |
| out_ready | input | 1 | Downstream takes the block this cycle |
| out_block | output | 66 | Coded block, sync header in bits 1:0 |

## Verification
The assertions assume that `in_ctrl` and `in_data` carry known values whenever `in_valid` is high. They also assume that the downstream side may drop `out_ready` on any cycle, so the hold and sequencing checks must survive arbitrary back-pressure. The stimulus changes a vector only after it has been accepted and always drives full defined octets. It pairs randomly gapped `in_valid` with a randomly toggling `out_ready`. Both directed runs of every terminate lane and random class sequences walk each row of the sequencing table.

// File: rtl/epon_enc_pkg.sv
package epon_enc_pkg;

   typedef enum logic [3:0] {
      CL_FAULT, CL_IEI, CL_START, CL_DATA, CL_TERM,
      CL_IDLE, CL_PARITY, CL_OTHER, CL_ERR
   } blk_class_e;

   // interface-side control characters
   localparam logic [7:0] XC_IDLE  = 8'h07;
   localparam logic [7:0] XC_IEI   = 8'h08;
   localparam logic [7:0] XC_PAR   = 8'h09;
   localparam logic [7:0] XC_ERR   = 8'hFE;
   localparam logic [7:0] XC_START = 8'hFB;
   localparam logic [7:0] XC_TERM  = 8'hFD;

   // line-side 7-bit control codes
   localparam logic [6:0] LC_IDLE = 7'h00;
   localparam logic [6:0] LC_IEI  = 7'h08;
   localparam logic [6:0] LC_PAR  = 7'h09;
   localparam logic [6:0] LC_ERR  = 7'h1E;

   localparam logic [7:0] BT_CTRL  = 8'h1E;
   localparam logic [7:0] BT_START = 8'h78;
   localparam logic [1:0] SH_DATA  = 2'b01;
   localparam logic [1:0] SH_CTRL  = 2'b10;

   function automatic logic [7:0] term_type(input logic [2:0] lane);
      logic [7:0] t;
      case (lane)
         3'd0:    t = 8'h87;
         3'd1:    t = 8'h99;
         3'd2:    t = 8'hAA;
         3'd3:    t = 8'hB4;
         3'd4:    t = 8'hCC;
         3'd5:    t = 8'hD2;
         3'd6:    t = 8'hE1;
         default: t = 8'hFF;
      endcase
      return t;
   endfunction

   function automatic logic ctrl_char_legal(input logic [7:0] oct);
      return (oct == XC_IDLE) || (oct == XC_IEI) || (oct == XC_PAR) || (oct == XC_ERR);
   endfunction

   // sequencing table: may class nxt follow a block of class prev
   function automatic logic next_allowed(input blk_class_e prev, input blk_class_e nxt);
      logic ok;
      if (nxt == CL_OTHER) ok = 1'b0;
      else begin
         case (prev)
            CL_FAULT:         ok = (nxt == CL_IEI);
            CL_IEI:           ok = (nxt == CL_IEI) || (nxt == CL_START) || (nxt == CL_PARITY);
            CL_TERM, CL_IDLE: ok = (nxt != CL_TERM);
            default:          ok = 1'b1;
         endcase
      end
      return ok;
   endfunction

endpackage

// File: rtl/epon_enc_classify.sv
module epon_enc_classify
   import epon_enc_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic [LANES-1:0]         ctrl,
   input  logic [8*LANES-1:0]       data,
   output blk_class_e               cls,
   output logic [$clog2(LANES)-1:0] term_lane
);
   localparam int LW = $clog2(LANES);
   localparam logic [LANES-1:0] ALL_LANES = '1;

   logic [LANES-1:0] l_idle, l_iei, l_par, l_legal, l_fd, term_hit;

   // per-lane octet decode
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] oct;
      assign oct        = data[8*i +: 8];
      assign l_idle[i]  = ctrl[i] && (oct == XC_IDLE);
      assign l_iei[i]   = ctrl[i] && (oct == XC_IEI);
      assign l_par[i]   = ctrl[i] && (oct == XC_PAR);
      assign l_legal[i] = ctrl[i] && ctrl_char_legal(oct);
      assign l_fd[i]    = (oct == XC_TERM);
   end

   // one terminate matcher per candidate lane
   for (genvar k = 0; k < LANES; k++) begin : g_term
      localparam logic [LANES-1:0] TMASK = ALL_LANES << k;
      localparam logic [LANES-1:0] TAIL  = ALL_LANES << (k + 1);
      assign term_hit[k] = (ctrl == TMASK) && l_fd[k] && ((l_legal & TAIL) == TAIL);
   end

   always_comb begin
      term_lane = '0;
      for (int k = 0; k < LANES; k++)
         if (term_hit[k]) term_lane = LW'(k);
   end

   always_comb begin
      if (ctrl == '0)                                      cls = CL_DATA;
      else if (ctrl == LANES'(1) && data[7:0] == XC_START) cls = CL_START;
      else if (&l_idle)                                    cls = CL_IDLE;
      else if (&l_iei)                                     cls = CL_IEI;
      else if (&l_par)                                     cls = CL_PARITY;
      else if (|term_hit)                                  cls = CL_TERM;
      else                                                 cls = CL_OTHER;
   end

endmodule

// File: rtl/epon_enc_build.sv
module epon_enc_build
   import epon_enc_pkg::*;
#(
   parameter int LANES = 8
) (
   input  blk_class_e               kind,
   input  logic [8*LANES-1:0]       data,
   input  logic [$clog2(LANES)-1:0] term_lane,
   output logic [8*LANES+1:0]       blk
);
   localparam int PW = 7 * LANES;

   logic [PW-1:0] keep;
   assign keep = ~({PW{1'b1}} << {term_lane, 3'b000});

   always_comb begin
      case (kind)
         CL_DATA:   blk = {data, SH_DATA};
         CL_START:  blk = {data[8*LANES-1:8], BT_START, SH_CTRL};
         CL_TERM:   blk = {data[PW-1:0] & keep, term_type(term_lane), SH_CTRL};
         CL_IDLE:   blk = {{LANES{LC_IDLE}}, BT_CTRL, SH_CTRL};
         CL_IEI:    blk = {{LANES{LC_IEI}},  BT_CTRL, SH_CTRL};
         CL_PARITY: blk = {{LANES{LC_PAR}},  BT_CTRL, SH_CTRL};
         default:   blk = {{LANES{LC_ERR}},  BT_CTRL, SH_CTRL};
      endcase
   end

endmodule

// File: rtl/epon_blk_encoder.sv
module epon_blk_encoder
   import epon_enc_pkg::*;
#(
   parameter int               LANES       = 8,
   parameter logic [7*LANES-1:0] FAULT_CODES = 56'h7F
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [LANES-1:0]     in_ctrl,
   input  logic [8*LANES-1:0]   in_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [8*LANES+1:0]   out_block
);
   localparam int LW = $clog2(LANES);
   localparam int BW = 8 * LANES + 2;
   localparam logic [BW-1:0] FAULT_BLK = {FAULT_CODES, BT_CTRL, SH_CTRL};
   localparam logic [BW-1:0] ERR_BLK   = {{LANES{LC_ERR}}, BT_CTRL, SH_CTRL};

   if (LANES != 8) begin : g_lane_chk
      $error("epon_blk_encoder: block formats are defined for eight lanes only");
   end
   if (FAULT_CODES == {LANES{LC_ERR}} || FAULT_CODES == {LANES{LC_IDLE}} ||
       FAULT_CODES == {LANES{LC_IEI}} || FAULT_CODES == {LANES{LC_PAR}}) begin : g_fault_chk
      $error("epon_blk_encoder: fault pattern collides with another control block");
   end

   blk_class_e       cls, emit_kind, prev_cls;
   logic [LW-1:0]    term_lane;
   logic [BW-1:0]    next_blk;
   logic             accept, seq_ok;

   epon_enc_classify #(.LANES(LANES)) u_classify (
      .ctrl      (in_ctrl),
      .data      (in_data),
      .cls       (cls),
      .term_lane (term_lane)
   );

   assign seq_ok    = next_allowed(prev_cls, cls);
   assign emit_kind = seq_ok ? cls : CL_ERR;

   epon_enc_build #(.LANES(LANES)) u_build (
      .kind      (emit_kind),
      .data      (in_data),
      .term_lane (term_lane),
      .blk       (next_blk)
   );

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   // prev_cls is the sequencing state: class of the block now in the output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b1;
         out_block <= FAULT_BLK;
         prev_cls  <= CL_FAULT;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_block <= next_blk;
         prev_cls  <= emit_kind;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   AST_FAULT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_block != FAULT_BLK);                                    // R1
   AST_SYNC_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_block[1:0] == SH_DATA || out_block[1:0] == SH_CTRL)); // R2
   AST_BLK_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_block[1:0] == SH_CTRL) |->
         (out_block[9:2] inside {8'h1E, 8'h78, 8'h87, 8'h99, 8'hAA,
                                 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF}));        // R3
   AST_FAULT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && prev_cls == CL_FAULT && cls != CL_IEI) |=> out_block == ERR_BLK); // R7
   AST_ERR_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cls == CL_OTHER) |=> out_block == ERR_BLK);                  // R9
   AST_ERR_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && prev_cls == CL_ERR && cls != CL_OTHER) |=> out_block != ERR_BLK); // R8
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_block)));       // R10

endmodule

// File: tb/test_epon_blk_encoder.sv
module test_epon_blk_encoder;
   localparam int CLK_PERIOD = 10;
   localparam logic [65:0] FAULT_EXP = {56'h7F, 8'h1E, 2'b10};

   // model class codes
   localparam int M_FAULT = 0, M_IEI = 1, M_S = 2, M_D = 3, M_T = 4,
                  M_I = 5, M_P = 6, M_OTH = 7, M_ERR = 8;

   logic        clk, rst_n, in_valid, in_ready, out_valid, out_ready;
   logic [7:0]  in_ctrl;
   logic [63:0] in_data;
   logic [65:0] out_block;

   epon_blk_encoder i_epon_blk_encoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_ctrl(in_ctrl), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_block(out_block)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   logic [71:0] stim[$];
   logic [65:0] exp_q[$];
   string       tag_q[$];
   int          m_prev;
   bit          run = 0, acc = 0, hold = 0;
   logic [65:0] blk_hold;
   logic [71:0] v;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [65:0] act, input logic [65:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   function automatic bit legal_cc(input logic [7:0] o);
      return o == 8'h07 || o == 8'h08 || o == 8'h09 || o == 8'hFE;
   endfunction

   function automatic int m_tlane(input logic [7:0] c);
      for (int k = 0; k < 8; k++) if (c[k]) return k;
      return 8;
   endfunction

   function automatic int m_class(input logic [7:0] c, input logic [63:0] d);
      int k;
      bit ok;
      if (c == 8'h00) return M_D;
      if (c == 8'h01 && d[7:0] == 8'hFB) return M_S;
      if (c == 8'hFF) begin
         if (d == {8{8'h07}}) return M_I;
         if (d == {8{8'h08}}) return M_IEI;
         if (d == {8{8'h09}}) return M_P;
      end
      k = m_tlane(c);
      if (k < 8) begin
         logic [7:0] want;
         want = 8'hFF << k;
         if (c == want && d[8*k +: 8] == 8'hFD) begin
            ok = 1;
            for (int j = k + 1; j < 8; j++) if (!legal_cc(d[8*j +: 8])) ok = 0;
            if (ok) return M_T;
         end
      end
      return M_OTH;
   endfunction

   function automatic bit m_allowed(input int p, input int n);
      if (n == M_OTH) return 0;
      if (p == M_FAULT) return n == M_IEI;
      if (p == M_IEI) return n == M_IEI || n == M_S || n == M_P;
      if (p == M_T || p == M_I) return n != M_T;
      return 1;
   endfunction

   function automatic logic [65:0] m_block(input int kind, input logic [7:0] c, input logic [63:0] d);
      logic [55:0] pl;
      logic [7:0]  t;
      int k;
      pl = '0;
      case (kind)
         M_D: return {d, 2'b01};
         M_S: return {d[63:8], 8'h78, 2'b10};
         M_T: begin
            k = m_tlane(c);
            for (int j = 0; j < k; j++) pl[8*j +: 8] = d[8*j +: 8];
            case (k)
               0: t = 8'h87; 1: t = 8'h99; 2: t = 8'hAA; 3: t = 8'hB4;
               4: t = 8'hCC; 5: t = 8'hD2; 6: t = 8'hE1; default: t = 8'hFF;
            endcase
            return {pl, t, 2'b10};
         end
         M_I:     begin for (int j = 0; j < 8; j++) pl[7*j +: 7] = 7'h00; return {pl, 8'h1E, 2'b10}; end
         M_IEI:   begin for (int j = 0; j < 8; j++) pl[7*j +: 7] = 7'h08; return {pl, 8'h1E, 2'b10}; end
         M_P:     begin for (int j = 0; j < 8; j++) pl[7*j +: 7] = 7'h09; return {pl, 8'h1E, 2'b10}; end
         default: begin for (int j = 0; j < 8; j++) pl[7*j +: 7] = 7'h1E; return {pl, 8'h1E, 2'b10}; end
      endcase
   endfunction

   // stimulus helpers
   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction
   task automatic put(input logic [7:0] c, input logic [63:0] d); stim.push_back({c, d}); endtask
   task automatic put_idle(); put(8'hFF, {8{8'h07}}); endtask
   task automatic put_iei();  put(8'hFF, {8{8'h08}}); endtask
   task automatic put_par();  put(8'hFF, {8{8'h09}}); endtask
   task automatic put_data(); put(8'h00, rnd64()); endtask
   task automatic put_start();
      logic [63:0] d;
      d = rnd64(); d[7:0] = 8'hFB; put(8'h01, d);
   endtask
   task automatic put_term(input int k);
      logic [63:0] d;
      logic [7:0]  fill [4];
      fill[0] = 8'h07; fill[1] = 8'h08; fill[2] = 8'h09; fill[3] = 8'hFE;
      d = rnd64();
      d[8*k +: 8] = 8'hFD;
      for (int j = k + 1; j < 8; j++) d[8*j +: 8] = fill[(j + k) % 4];
      put(8'hFF << k, d);
   endtask

   // per-cycle driver, reference model and comparison, away from the rising edge
   always @(negedge clk) begin
      if (run) begin
         if (!in_valid || acc) begin
            if (stim.size() > 0 && ($urandom % 5) != 0) begin
               v = stim.pop_front();
               in_ctrl = v[71:64]; in_data = v[63:0]; in_valid = 1'b1;
            end else in_valid = 1'b0;
         end
         out_ready = ($urandom % 10) < 7;
         #1;
         chk(in_ready == (!out_valid || out_ready), "R10", "in_ready", {65'b0, in_ready},
             {65'b0, (!out_valid || out_ready)});
         if (hold) chk(out_valid && out_block == blk_hold, "R10", "held block", out_block, blk_hold);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R10", "unexpected block", out_block, '0);
            else begin
               logic [65:0] e;
               string       tg;
               e = exp_q.pop_front(); tg = tag_q.pop_front();
               chk(out_block == e, tg, "block", out_block, e);
               if (out_block[1:0] == 2'b10)
                  chk(out_block[9:2] inside {8'h1E, 8'h78, 8'h87, 8'h99, 8'hAA, 8'hB4,
                                             8'hCC, 8'hD2, 8'hE1, 8'hFF},
                      "R3", "block type", {58'b0, out_block[9:2]}, {58'b0, e[9:2]});
            end
         end
         if (in_valid && in_ready) begin
            int n;
            string tg;
            n = m_class(in_ctrl, in_data);
            if (!m_allowed(m_prev, n)) begin
               tg = (n == M_OTH) ? "R9" : "R7";
               exp_q.push_back(m_block(M_ERR, in_ctrl, in_data));
               m_prev = M_ERR;
            end else begin
               case (n)
                  M_D: tg = "R2"; M_S: tg = "R5"; M_T: tg = "R6"; default: tg = "R4";
               endcase
               if (m_prev == M_ERR) tg = "R8";
               exp_q.push_back(m_block(n, in_ctrl, in_data));
               m_prev = n;
            end
            tag_q.push_back(tg);
            acc = 1;
         end else acc = 0;
         hold = out_valid && !out_ready;
         blk_hold = out_block;
      end
   end

   initial begin
      int cycles;
      logic [63:0] d;
      rst_n = 1'b0; in_valid = 1'b0; in_ctrl = '0; in_data = '0; out_ready = 1'b0;

      // directed sequence
      put_idle();                        // R7: idle straight after local fault
      put_iei(); put_iei(); put_par();
      put_start(); put_data(); put_data();
      for (int k = 0; k < 8; k++) begin  // R6: every terminate lane
         put_start(); put_data(); put_term(k); put_idle();
      end
      put_term(2);                       // R7: terminate after idle
      put_term(2);                       // R8: terminate after error is allowed
      put_term(5);                       // R7: terminate after terminate
      put_par();                         // R8
      d = {8{8'h07}}; d[63:56] = 8'h08;
      put(8'hFF, d);                     // R9: mixed control characters
      d = rnd64(); d[39:32] = 8'hFD; d[47:40] = 8'h55; d[55:48] = 8'h07; d[63:56] = 8'h07;
      put(8'hF0, d);                     // R9: illegal character after terminate
      d = rnd64(); d[7:0] = 8'hFC;
      put(8'h01, d);                     // R9: lane 0 flagged without start
      put_iei(); put_data();             // R7: data after inter-envelope idle
      put_start(); put_data();
      // random class sequences
      for (int n = 0; n < 400; n++) begin
         case ($urandom % 7)
            0: put_idle();
            1: put_iei();
            2: put_par();
            3: put_start();
            4: put_data();
            5: put_term($urandom % 8);
            default: put($urandom, rnd64());
         endcase
      end

      repeat (3) @(negedge clk);
      chk(out_valid == 1'b1, "R1", "out_valid in reset", {65'b0, out_valid}, 66'd1);
      chk(out_block == FAULT_EXP, "R1", "block in reset", out_block, FAULT_EXP);
      rst_n = 1'b1;
      m_prev = M_FAULT;
      exp_q.push_back(FAULT_EXP); tag_q.push_back("R1");
      #2 run = 1;

      cycles = 0;
      while ((stim.size() > 0 || exp_q.size() > 0 || in_valid) && cycles < 20000) begin
         @(posedge clk);
         cycles++;
      end
      if (cycles >= 20000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      end
      run = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule